// File: doc/BRIEF.md
# Core Idle-State Sequencer

This block moves one multi-threaded core between running and three idle depths: a light halt in which clocks keep running, a clock-stopped sleep, and a power-gated sleep. Each thread raises an idle request and names a depth. It can name the depth through a monitor-wait hint or through a read of a power-level I/O port. The core starts an entry only when every thread is idle, and it takes the shallowest depth that any thread asked for.

The deeper entries run as ordered handshakes with outside engines. The private caches are written back before the clocks stop. Architectural state is copied to retention storage before the supply is cut. When the core wakes from the gated depth, power returns first and the saved state is reloaded next. Each handshake has a watchdog counter. If a thread wakes during an entry, the entry is abandoned. A wake event that arrives during an entry is held and acted on when the running handshake completes. Whether a snoop is accepted depends only on the current state. A system-management interrupt taken from light halt returns to the state chosen by a return-select input.

Top module: `cidle_seq`

## Requirements
- R1: No entry starts while any thread has `thr_idle` low. The sequencer leaves ACTIVE only when all bits of `thr_idle` are high and `wake_evt` is low.
- R2: The depth granted is the minimum of the depths the threads request, ordered light < clock-stop < power-gate. A light grant goes straight to LIGHT. The deeper grants go to FLUSH.
- R3: Depth decoding, for each thread. With `thr_src`=0 (monitor-wait), an arg of 1 gives clock-stop, 2 gives power-gate, and 0 or 3 give light. With `thr_src`=1 (power-level port read), an arg of 0 gives clock-stop, 1 gives power-gate, and 2 or 3 give light.
- R4: In FLUSH, `flush_req` is high and `clk_en` stays high. `flush_done` takes a clock-stop grant to CLKSTOP and a power-gate grant to SAVE. `clk_en` is low only in CLKSTOP, PGATE and PWRUP.
- R5: `snoop_ack` follows `snoop_req` in ACTIVE, LIGHT, SMM and FLUSH, and is low in every other state. CLKSTOP is left only on `wake_evt`, never on a snoop.
- R6: In SAVE, `save_req` is high and `pwr_gate` is low. Only `save_done` leads to PGATE, where `pwr_gate` is high and `clk_en` is low.
- R7: `wake_evt` in PGATE leads to PWRUP, with `pwr_gate` low. `pwr_good` then leads to RESTORE, with `restore_req` high. `restore_done` then leads to ACTIVE.
- R8: `smi_req` in LIGHT leads to SMM. In SMM, `smi_done` returns to LIGHT when `smi_ret_light` is 1 and to ACTIVE when it is 0.
- R9: If any `thr_idle` bit falls during FLUSH or SAVE, the next state is ACTIVE.
- R10: If a handshake state (FLUSH, SAVE, PWRUP, RESTORE) lasts TO_CYCLES cycles without its done input, the sequencer goes to ACTIVE and sets the sticky `hs_err` flag.
- R11: A `wake_evt` pulse seen during FLUSH or SAVE is held. When the handshake completes, the sequencer goes to ACTIVE instead of going deeper.
- R12: `cur_state` codes are ACTIVE=0, LIGHT=1, FLUSH=2, CLKSTOP=3, SAVE=4, PGATE=5, PWRUP=6, RESTORE=7, SMM=8. After reset the state is ACTIVE with `clk_en`=1, all requests low and `hs_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_idle | input | NTHREADS | Per-thread idle request (level) |
| thr_src | input | NTHREADS | Per-thread request source: 0 monitor-wait, 1 port read |
| thr_arg | input | 2*NTHREADS | Per-thread depth hint or port level, 2 bits each |
| snoop_req | input | 1 | Incoming snoop |
| wake_evt | input | 1 | Wake event |
| smi_req | input | 1 | System-management interrupt |
| smi_done | input | 1 | Interrupt handler finished |
| smi_ret_light | input | 1 | Handler return target: 1 LIGHT, 0 ACTIVE |
| flush_done | input | 1 | Cache write-back complete |
| save_done | input | 1 | State save complete |
| pwr_good | input | 1 | Supply restored |
| restore_done | input | 1 | State reload complete |
| flush_req | output | 1 | Cache write-back request |
| clk_en | output | 1 | Core clock enable |
| save_req | output | 1 | State save request |
| restore_req | output | 1 | State reload request |
| pwr_gate | output | 1 | Remove core supply |
| snoop_ack | output | 1 | Snoop accepted |
| hs_err | output | 1 | Sticky handshake-timeout flag |
| cur_state | output | 4 | Current state code |

## Verification
The depth merge is tried with three input patterns. One thread idle and the other not must leave the core active. Mixed depths must settle on the shallower one. Pairs that use the two request sources with the same argument value must separate the two decode tables. Each deep path is walked one handshake at a time, and each done input is held back for a while, so a design that jumps ahead of a handshake is caught. Snoops, a thread waking, a wake pulse during a write-back, and a stalled write-back are each applied at one chosen point in a sequence. This separates accepting from ignoring, cancelling from latching, and a done input from a timeout.

// File: rtl/cidle_pkg.sv
package cidle_pkg;

  typedef enum logic [1:0] {
    DP_NONE  = 2'd0,
    DP_LIGHT = 2'd1,
    DP_CSTOP = 2'd2,
    DP_PGATE = 2'd3
  } depth_e;

  typedef enum logic [3:0] {
    S_ACTIVE  = 4'd0,
    S_LIGHT   = 4'd1,
    S_FLUSH   = 4'd2,
    S_CLKSTOP = 4'd3,
    S_SAVE    = 4'd4,
    S_PGATE   = 4'd5,
    S_PWRUP   = 4'd6,
    S_RESTORE = 4'd7,
    S_SMM     = 4'd8
  } cstate_e;

  // Per-thread request decode (R3)
  function automatic depth_e decode_depth(input logic src, input logic [1:0] arg);
    depth_e d;
    if (!src) begin
      case (arg)
        2'd1:    d = DP_CSTOP;
        2'd2:    d = DP_PGATE;
        default: d = DP_LIGHT;
      endcase
    end else begin
      case (arg)
        2'd0:    d = DP_CSTOP;
        2'd1:    d = DP_PGATE;
        default: d = DP_LIGHT;
      endcase
    end
    return d;
  endfunction

  function automatic depth_e depth_min(input depth_e a, input depth_e b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic snoop_ok(input cstate_e s);
    return (s == S_ACTIVE) || (s == S_LIGHT) || (s == S_SMM) || (s == S_FLUSH);
  endfunction

  function automatic logic clocks_on(input cstate_e s);
    return !((s == S_CLKSTOP) || (s == S_PGATE) || (s == S_PWRUP));
  endfunction

  function automatic logic is_handshake(input cstate_e s);
    return (s == S_FLUSH) || (s == S_SAVE) || (s == S_PWRUP) || (s == S_RESTORE);
  endfunction

endpackage

// File: rtl/cidle_req_merge.sv
module cidle_req_merge
  import cidle_pkg::*;
#(
  parameter int NTHREADS = 2
) (
  input  logic [NTHREADS-1:0]   thr_idle,
  input  logic [NTHREADS-1:0]   thr_src,
  input  logic [2*NTHREADS-1:0] thr_arg,
  output logic                  all_idle,
  output logic                  any_awake,
  output depth_e                min_depth
);

  depth_e thr_depth [NTHREADS];

  for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
    assign thr_depth[t] = decode_depth(thr_src[t], thr_arg[2*t +: 2]);
  end

  always_comb begin
    depth_e m;
    m = DP_PGATE;
    for (int t = 0; t < NTHREADS; t++) begin
      m = depth_min(m, thr_depth[t]);
    end
    min_depth = m;
  end

  assign all_idle  = &thr_idle;
  assign any_awake = ~all_idle;

endmodule

// File: rtl/cidle_hs_timer.sv
module cidle_hs_timer #(
  parameter int TO_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic expired
);

  localparam int CW = $clog2(TO_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run || clr) cnt_q <= '0;
    else if (!expired)         cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == CW'(TO_CYCLES - 1));

endmodule

// File: rtl/cidle_wake_latch.sv
module cidle_wake_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic wake_evt,
  output logic wake_seen
);

  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   pend_q <= 1'b0;
    else if (arm) pend_q <= pend_q | wake_evt;
    else          pend_q <= 1'b0;
  end

  assign wake_seen = pend_q | wake_evt;

endmodule

// File: rtl/cidle_seq.sv
module cidle_seq
  import cidle_pkg::*;
#(
  parameter int NTHREADS  = 2,
  parameter int TO_CYCLES = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NTHREADS-1:0]   thr_idle,
  input  logic [NTHREADS-1:0]   thr_src,
  input  logic [2*NTHREADS-1:0] thr_arg,
  input  logic                  snoop_req,
  input  logic                  wake_evt,
  input  logic                  smi_req,
  input  logic                  smi_done,
  input  logic                  smi_ret_light,
  input  logic                  flush_done,
  input  logic                  save_done,
  input  logic                  pwr_good,
  input  logic                  restore_done,
  output logic                  flush_req,
  output logic                  clk_en,
  output logic                  save_req,
  output logic                  restore_req,
  output logic                  pwr_gate,
  output logic                  snoop_ack,
  output logic                  hs_err,
  output logic [3:0]            cur_state
);

  cstate_e state_q, state_d;
  depth_e  grant_q, grant_d;
  depth_e  min_depth;
  logic    all_idle, any_awake;
  logic    hs_timeout, to_fire;
  logic    wake_seen, entry_arm, st_change;
  logic    err_q;

  cidle_req_merge #(.NTHREADS(NTHREADS)) u_merge (
    .thr_idle  (thr_idle),
    .thr_src   (thr_src),
    .thr_arg   (thr_arg),
    .all_idle  (all_idle),
    .any_awake (any_awake),
    .min_depth (min_depth)
  );

  assign st_change = (state_d != state_q);

  cidle_hs_timer #(.TO_CYCLES(TO_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (is_handshake(state_q)),
    .clr     (st_change),
    .expired (hs_timeout)
  );

  assign entry_arm = (state_q == S_FLUSH) || (state_q == S_SAVE);

  cidle_wake_latch u_wake (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (entry_arm),
    .wake_evt  (wake_evt),
    .wake_seen (wake_seen)
  );

  always_comb begin
    state_d = state_q;
    grant_d = grant_q;
    to_fire = 1'b0;
    unique case (state_q)
      S_ACTIVE: begin
        if (all_idle && !wake_evt) begin
          grant_d = min_depth;
          if (min_depth == DP_LIGHT) state_d = S_LIGHT;
          else if (min_depth != DP_NONE) state_d = S_FLUSH;
        end
      end
      S_LIGHT: begin
        if (wake_evt || any_awake) state_d = S_ACTIVE;
        else if (smi_req)          state_d = S_SMM;
      end
      S_SMM: begin
        if (smi_done) state_d = smi_ret_light ? S_LIGHT : S_ACTIVE;
      end
      S_FLUSH: begin
        if (any_awake) state_d = S_ACTIVE;
        else if (flush_done) begin
          if (wake_seen)                 state_d = S_ACTIVE;
          else if (grant_q == DP_CSTOP)  state_d = S_CLKSTOP;
          else                           state_d = S_SAVE;
        end else if (hs_timeout) begin
          state_d = S_ACTIVE;
          to_fire = 1'b1;
        end
      end
      S_SAVE: begin
        if (any_awake) state_d = S_ACTIVE;
        else if (save_done) state_d = wake_seen ? S_ACTIVE : S_PGATE;
        else if (hs_timeout) begin
          state_d = S_ACTIVE;
          to_fire = 1'b1;
        end
      end
      S_CLKSTOP: begin
        if (wake_evt) state_d = S_ACTIVE;
      end
      S_PGATE: begin
        if (wake_evt) state_d = S_PWRUP;
      end
      S_PWRUP: begin
        if (pwr_good) state_d = S_RESTORE;
        else if (hs_timeout) begin
          state_d = S_ACTIVE;
          to_fire = 1'b1;
        end
      end
      S_RESTORE: begin
        if (restore_done) state_d = S_ACTIVE;
        else if (hs_timeout) begin
          state_d = S_ACTIVE;
          to_fire = 1'b1;
        end
      end
      default: state_d = S_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_ACTIVE;
      grant_q <= DP_NONE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      grant_q <= grant_d;
      err_q   <= err_q | to_fire;
    end
  end

  assign flush_req   = (state_q == S_FLUSH);
  assign save_req    = (state_q == S_SAVE);
  assign restore_req = (state_q == S_RESTORE);
  assign pwr_gate    = (state_q == S_PGATE);
  assign clk_en      = clocks_on(state_q);
  assign snoop_ack   = snoop_req && snoop_ok(state_q);
  assign hs_err      = err_q;
  assign cur_state   = state_q;

endmodule

// File: rtl/cidle_seq_chk.sv
module cidle_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cur_state,
  input logic       all_idle,
  input logic       flush_done,
  input logic       save_done,
  input logic       pwr_good,
  input logic       wake_evt,
  input logic       snoop_ack,
  input logic       clk_en,
  input logic       pwr_gate,
  input logic       save_req,
  input logic       hs_err
);

  p_light_needs_all_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == 4'd1 && $past(cur_state) == 4'd0) |-> $past(all_idle));

  p_flush_before_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == 4'd3 && $past(cur_state) != 4'd3) |->
      ($past(cur_state) == 4'd2 && $past(flush_done)));

  p_no_snoop_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == 4'd3) |-> !snoop_ack);

  p_save_before_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == 4'd5 && $past(cur_state) != 4'd5) |->
      ($past(cur_state) == 4'd4 && $past(save_done)));

  p_gate_clocks_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_gate |-> (!clk_en && !save_req));

  p_exit_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == 4'd7 && $past(cur_state) != 4'd7) |->
      ($past(cur_state) == 4'd6 && $past(pwr_good)));

  p_wake_to_pwrup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == 4'd5 && wake_evt) |=> (cur_state == 4'd6));

  p_err_goes_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_err) |-> (cur_state == 4'd0));

endmodule

bind cidle_seq cidle_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cur_state  (cur_state),
  .all_idle   (all_idle),
  .flush_done (flush_done),
  .save_done  (save_done),
  .pwr_good   (pwr_good),
  .wake_evt   (wake_evt),
  .snoop_ack  (snoop_ack),
  .clk_en     (clk_en),
  .pwr_gate   (pwr_gate),
  .save_req   (save_req),
  .hs_err     (hs_err)
);

// File: tb/cidle_seq_tb.sv
module cidle_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NT = 2;
  localparam int TO = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic [NT-1:0]   thr_idle, thr_src;
  logic [2*NT-1:0] thr_arg;
  logic snoop_req, wake_evt, smi_req, smi_done, smi_ret_light;
  logic flush_done, save_done, pwr_good, restore_done;
  logic flush_req, clk_en, save_req, restore_req, pwr_gate, snoop_ack, hs_err;
  logic [3:0] cur_state;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cidle_seq #(.NTHREADS(NT), .TO_CYCLES(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .thr_idle(thr_idle), .thr_src(thr_src), .thr_arg(thr_arg),
    .snoop_req(snoop_req), .wake_evt(wake_evt), .smi_req(smi_req), .smi_done(smi_done),
    .smi_ret_light(smi_ret_light), .flush_done(flush_done), .save_done(save_done),
    .pwr_good(pwr_good), .restore_done(restore_done), .flush_req(flush_req),
    .clk_en(clk_en), .save_req(save_req), .restore_req(restore_req), .pwr_gate(pwr_gate),
    .snoop_ack(snoop_ack), .hs_err(hs_err), .cur_state(cur_state)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic set_thr(input logic [NT-1:0] idle, input logic [NT-1:0] src, input logic [2*NT-1:0] arg);
    thr_idle = idle;
    thr_src  = src;
    thr_arg  = arg;
  endtask

  task automatic t_reset;
    chk("R12", "state", cur_state, 0);
    chk("R12", "clk_en", clk_en, 1);
    chk("R12", "requests", {flush_req, save_req, restore_req, pwr_gate}, 0);
    chk("R12", "hs_err", hs_err, 0);
  endtask

  task automatic t_partial_r1;
    set_thr(2'b01, 2'b00, 4'b0000);
    step(2);
    chk("R1", "one thread awake", cur_state, 0);
    set_thr(2'b00, 2'b00, 4'b0000);
  endtask

  task automatic t_min_r2;
    // thread0 monitor-wait power-gate, thread1 monitor-wait light
    set_thr(2'b11, 2'b00, {2'd0, 2'd2});
    step();
    chk("R2", "min depth light", cur_state, 1);
    snoop_req = 1'b1;
    #1;
    chk("R5", "snoop in light", snoop_ack, 1);
    snoop_req = 1'b0;
    wake_evt = 1'b1;
    set_thr(2'b00, 2'b00, 4'b0000);
    step();
    chk("R5", "wake leaves light", cur_state, 0);
    wake_evt = 1'b0;
  endtask

  task automatic t_clkstop_r4;
    // thread0 port read level 0, thread1 monitor-wait 1: both clock-stop
    set_thr(2'b11, 2'b01, {2'd1, 2'd0});
    step();
    chk("R3", "decode clock-stop", cur_state, 2);
    chk("R4", "flush_req", flush_req, 1);
    chk("R4", "clk_en during flush", clk_en, 1);
    step(2);
    chk("R4", "waits for flush_done", cur_state, 2);
    flush_done = 1'b1;
    step();
    flush_done = 1'b0;
    chk("R4", "clock stopped", cur_state, 3);
    chk("R4", "clk_en off", clk_en, 0);
    snoop_req = 1'b1;
    step(2);
    chk("R5", "snoop ignored ack", snoop_ack, 0);
    chk("R5", "snoop does not wake", cur_state, 3);
    snoop_req = 1'b0;
    wake_evt = 1'b1;
    set_thr(2'b00, 2'b00, 4'b0000);
    step();
    wake_evt = 1'b0;
    chk("R5", "wake exits clock-stop", cur_state, 0);
  endtask

  task automatic t_pgate_r6_r7;
    // thread0 port read level 1 and thread1 monitor-wait 2: both power-gate
    set_thr(2'b11, 2'b01, {2'd2, 2'd1});
    step();
    flush_done = 1'b1;
    step();
    flush_done = 1'b0;
    chk("R3", "decode power-gate", cur_state, 4);
    chk("R6", "save_req", save_req, 1);
    chk("R6", "no gate in save", pwr_gate, 0);
    step(3);
    chk("R6", "waits for save_done", cur_state, 4);
    save_done = 1'b1;
    step();
    save_done = 1'b0;
    chk("R6", "gated", cur_state, 5);
    chk("R6", "pwr_gate", pwr_gate, 1);
    chk("R6", "clk_en off gated", clk_en, 0);
    wake_evt = 1'b1;
    set_thr(2'b00, 2'b00, 4'b0000);
    step();
    wake_evt = 1'b0;
    chk("R7", "power-up state", cur_state, 6);
    chk("R7", "gate released", pwr_gate, 0);
    step(2);
    chk("R7", "waits for pwr_good", cur_state, 6);
    pwr_good = 1'b1;
    step();
    pwr_good = 1'b0;
    chk("R7", "restore state", cur_state, 7);
    chk("R7", "restore_req", restore_req, 1);
    restore_done = 1'b1;
    step();
    restore_done = 1'b0;
    chk("R7", "back to active", cur_state, 0);
  endtask

  task automatic t_smi_r8;
    set_thr(2'b11, 2'b00, 4'b0000);
    step();
    chk("R8", "light before smi", cur_state, 1);
    smi_req = 1'b1;
    step();
    smi_req = 1'b0;
    chk("R8", "smm entered", cur_state, 8);
    smi_done = 1'b1;
    smi_ret_light = 1'b1;
    step();
    chk("R8", "return to light", cur_state, 1);
    smi_done = 1'b0;
    smi_req = 1'b1;
    step();
    smi_req = 1'b0;
    smi_done = 1'b1;
    smi_ret_light = 1'b0;
    step();
    smi_done = 1'b0;
    set_thr(2'b00, 2'b00, 4'b0000);
    chk("R8", "return to active", cur_state, 0);
    step();
  endtask

  task automatic t_cancel_r9;
    set_thr(2'b11, 2'b00, {2'd1, 2'd1});
    step();
    chk("R9", "flush entered", cur_state, 2);
    thr_idle = 2'b10;
    step();
    chk("R9", "cancelled", cur_state, 0);
    chk("R9", "flush_req dropped", flush_req, 0);
    thr_idle = 2'b00;
  endtask

  task automatic t_wake_latch_r11;
    set_thr(2'b11, 2'b00, {2'd1, 2'd1});
    step();
    wake_evt = 1'b1;
    step();
    wake_evt = 1'b0;
    chk("R11", "still flushing", cur_state, 2);
    step(2);
    flush_done = 1'b1;
    step();
    flush_done = 1'b0;
    set_thr(2'b00, 2'b00, 4'b0000);
    chk("R11", "latched wake to active", cur_state, 0);
    step();
  endtask

  task automatic t_timeout_r10;
    set_thr(2'b11, 2'b00, {2'd1, 2'd1});
    step();
    chk("R10", "flush entered", cur_state, 2);
    step(TO - 1);
    chk("R10", "flush before limit", cur_state, 2);
    chk("R10", "no err before limit", hs_err, 0);
    step();
    set_thr(2'b00, 2'b00, 4'b0000);
    chk("R10", "timeout to active", cur_state, 0);
    chk("R10", "err set", hs_err, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    set_thr(2'b00, 2'b00, 4'b0000);
    snoop_req = 0; wake_evt = 0; smi_req = 0; smi_done = 0; smi_ret_light = 0;
    flush_done = 0; save_done = 0; pwr_good = 0; restore_done = 0;
    step(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_partial_r1();
    t_min_r2();
    t_clkstop_r4();
    t_pgate_r6_r7();
    t_smi_r8();
    t_cancel_r9();
    t_wake_latch_r11();
    t_timeout_r10();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule